// File: doc/BRIEF.md
# Link PHY Compliance Pattern Generator

This block drives one lane of a serial display link with physical-layer compliance patterns. A raw pattern-select byte, a flag that says whether the sink reports protocol revision 1.2, and a one-cycle start strobe choose the pattern. The block then runs a fixed bring-up order: link output off, datapath reset, pattern state cleared, and then the selected pattern runs. Any later change of selection takes effect only through another start.

The unscrambled patterns leave the block as finished 10-bit line symbols that bypass the 8b/10b encoder. These are the D10.2 clock pattern, PRBS7 and an 80-bit custom word. The two scrambled patterns leave as bytes with a control-character flag for an external encoder. These are the symbol-error-measurement pattern and the high-rate eye pattern. In both, the scrambler restarts at a fixed symbol interval, and a control character marks each restart.

Top module: `phy_pattern_gen`

## Requirements
- R1: The select code is `sel_raw[2:0]` when `rev12` is high and `{0, sel_raw[1:0]}` otherwise. The upper bits of `sel_raw` are ignored. Code 0 is none, 1 is D10.2, 2 is symbol-error measurement, 3 is PRBS7, 4 is the custom word and 5 is the eye pattern.
- R2: A start with a code above 5 raises `sel_err` on the next cycle. `link_on` stays low and all outputs stay zero. A later valid start clears `sel_err`.
- R3: A valid start sampled at edge k gives one cycle each of disable, reset and clear, with all outputs zero. `link_on` rises at edge k+3, and the first pattern symbol is shown in that same cycle.
- R4: While a pattern runs, a change of `sel_raw` or `rev12` without a start has no effect. A new start restarts the pattern from its seed.
- R5: D10.2 outputs `sym` = 10'b0101010101 every cycle with `sym_raw` high.
- R6: PRBS7 uses x^7+x^6+1 with state seeded to 7'h7F. Each bit is s[6]^s[5], and that bit is shifted into s[0]. Ten bits make one symbol, and the first bit goes into `sym[0]`. `sym_raw` is high.
- R7: The custom pattern is the 80-bit word 80'hF83E_0F83E0F8_3E0F83E0. It is sent as eight 10-bit chunks, starting with bits 9:0 and ascending, and it repeats with no gap. `sym_raw` is high.
- R8: In modes 2 and 5, `scr_valid` is high, `sym` is zero and `sym_raw` is low. Symbol 0 of every `SCR_PERIOD`-symbol period is a control character with `scr_ctrl` high and no scrambling. The character is 8'hBC in the eye mode and 8'h1C in the symbol-error mode.
- R9: The other symbols are the byte 0x00 scrambled LSB first with a Galois LFSR. The LFSR is x^16+x^5+x^4+x^3+1, with taps 16'h0039 and output bit 15. It is reset to 16'hFFFF at each control character and advanced 8 steps per data symbol.
- R10: With code 0 running, every output is zero and `link_on` is high.
- R11: A synchronous active-high `rst` returns the block to idle. `link_on` and `sel_err` go low and the outputs go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_raw | input | 8 | Raw pattern-select byte from the sink |
| rev12 | input | 1 | Sink reports protocol revision 1.2 |
| start | input | 1 | One-cycle strobe that starts the selected pattern |
| sym | output | 10 | Line symbol that bypasses the encoder |
| sym_raw | output | 1 | `sym` carries a pattern symbol |
| scr_byte | output | 8 | Byte for the external encoder in the scrambled modes |
| scr_ctrl | output | 1 | `scr_byte` is a control character |
| scr_valid | output | 1 | The scrambled byte path is active |
| link_on | output | 1 | Link output enabled, pattern running |
| sel_err | output | 1 | Last start carried an unsupported code |

## Verification
The bench builds the block with `SCR_PERIOD` = 12 rather than 252. Several whole scrambler periods, with their control characters and LFSR restarts, then fit in a short run. Every value of the raw select byte is swept under both revision settings, which covers masking and rejection exhaustively. The PRBS7 stream is followed past its full 127-bit cycle, and the custom word across several wraps.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int SYM_W  = 10;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    PAT_NONE = 3'd0, PAT_D102 = 3'd1, PAT_SEM = 3'd2,
    PAT_PRBS7 = 3'd3, PAT_CUST80 = 3'd4, PAT_EYE = 3'd5
  } pat_e;

  typedef enum logic [2:0] {ST_IDLE, ST_DIS, ST_RST, ST_CLR, ST_RUN} seq_e;

  localparam logic [SYM_W-1:0]  D102_SYM   = 10'b0101010101;
  localparam logic [79:0]       CUST_WORD  = 80'hF83E_0F83E0F8_3E0F83E0;
  localparam logic [6:0]        PRBS_SEED  = 7'h7F;
  localparam logic [15:0]       SCR_SEED   = 16'hFFFF;
  localparam logic [15:0]       SCR_TAPS   = 16'h0039;
  localparam logic [BYTE_W-1:0] K_EYE      = 8'hBC;
  localparam logic [BYTE_W-1:0] K_SEM      = 8'h1C;

  function automatic logic [CODE_W-1:0] mask_code(input logic [7:0] raw, input logic r12);
    return r12 ? raw[2:0] : {1'b0, raw[1:0]};
  endfunction

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return c <= 3'd5;
  endfunction

  // returns {next_state, symbol}
  function automatic logic [16:0] prbs_sym(input logic [6:0] s_in);
    logic [6:0] s;
    logic [SYM_W-1:0] y;
    logic b;
    s = s_in;
    y = '0;
    for (int i = 0; i < SYM_W; i++) begin
      b = s[6] ^ s[5];
      y[i] = b;
      s = {s[5:0], b};
    end
    return {s, y};
  endfunction

  // returns {next_lfsr, scrambled byte}
  function automatic logic [23:0] scr_step(input logic [15:0] l_in, input logic [7:0] d);
    logic [15:0] l;
    logic [7:0] y;
    logic fb;
    l = l_in;
    y = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = l[15];
      y[i] = d[i] ^ fb;
      l = {l[14:0], 1'b0} ^ (fb ? SCR_TAPS : 16'h0000);
    end
    return {l, y};
  endfunction
endpackage

// File: rtl/pg_seq.sv
module pg_seq
  import pg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        sel_raw,
  input  logic              rev12,
  output logic [CODE_W-1:0] active_code,
  output logic              seq_dis,
  output logic              seq_rst,
  output logic              seq_clr,
  output logic              running,
  output logic              sel_err
);
  seq_e st;
  logic [CODE_W-1:0] m_code;
  logic m_ok;

  always_comb begin
    m_code = mask_code(sel_raw, rev12);
    m_ok   = code_ok(m_code);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      active_code <= PAT_NONE;
      sel_err     <= 1'b0;
    end else if (start) begin
      if (m_ok) begin
        st          <= ST_DIS;
        active_code <= m_code;
        sel_err     <= 1'b0;
      end else begin
        st          <= ST_IDLE;
        active_code <= PAT_NONE;
        sel_err     <= 1'b1;
      end
    end else begin
      case (st)
        ST_DIS:  st <= ST_RST;
        ST_RST:  st <= ST_CLR;
        ST_CLR:  st <= ST_RUN;
        default: st <= st;
      endcase
    end
  end

  assign seq_dis = (st == ST_DIS);
  assign seq_rst = (st == ST_RST);
  assign seq_clr = (st == ST_CLR);
  assign running = (st == ST_RUN);
endmodule

// File: rtl/pg_prbs7.sv
module pg_prbs7
  import pg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             adv,
  output logic [SYM_W-1:0] sym
);
  logic [6:0]  st;
  logic [16:0] nxt;

  always_comb nxt = prbs_sym(st);
  assign sym = nxt[SYM_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || clear) st <= PRBS_SEED;
    else if (adv)     st <= nxt[16:SYM_W];
  end
endmodule

// File: rtl/pg_cust80.sv
module pg_cust80
  import pg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             adv,
  output logic [SYM_W-1:0] sym
);
  localparam int CHUNKS = 80 / SYM_W;
  localparam int IDX_W  = $clog2(CHUNKS);
  logic [IDX_W-1:0] idx;

  assign sym = CUST_WORD[idx*SYM_W +: SYM_W];

  always_ff @(posedge clk) begin
    if (rst || clear) idx <= '0;
    else if (adv)     idx <= (idx == IDX_W'(CHUNKS-1)) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/pg_scr.sv
module pg_scr
  import pg_pkg::*;
#(
  parameter int PERIOD = 252
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              adv,
  input  logic              eye,
  output logic [BYTE_W-1:0] dout,
  output logic              ctrl
);
  localparam int CNT_W = $clog2(PERIOD);
  logic [CNT_W-1:0] cnt;
  logic [15:0]      lfsr;
  logic [23:0]      nxt;

  always_comb nxt = scr_step(lfsr, 8'h00);
  assign ctrl = (cnt == '0);
  assign dout = ctrl ? (eye ? K_EYE : K_SEM) : nxt[7:0];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt  <= '0;
      lfsr <= SCR_SEED;
    end else if (adv) begin
      cnt  <= (cnt == CNT_W'(PERIOD-1)) ? '0 : cnt + 1'b1;
      lfsr <= ctrl ? SCR_SEED : nxt[23:8];
    end
  end
endmodule

// File: rtl/phy_pattern_gen.sv
module phy_pattern_gen
  import pg_pkg::*;
#(
  parameter int SCR_PERIOD = 252
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  sel_raw,
  input  logic        rev12,
  input  logic        start,
  output logic [9:0]  sym,
  output logic        sym_raw,
  output logic [7:0]  scr_byte,
  output logic        scr_ctrl,
  output logic        scr_valid,
  output logic        link_on,
  output logic        sel_err
);
  logic [CODE_W-1:0] active_code;
  logic seq_dis, seq_rst, seq_clr, running;
  logic run_prbs, run_cust, run_d102, run_scr;
  logic [SYM_W-1:0]  prbs_s, cust_s;
  logic [BYTE_W-1:0] scr_d;
  logic              scr_k;

  pg_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .sel_raw(sel_raw), .rev12(rev12),
    .active_code(active_code), .seq_dis(seq_dis), .seq_rst(seq_rst),
    .seq_clr(seq_clr), .running(running), .sel_err(sel_err)
  );

  assign run_d102 = running && (active_code == PAT_D102);
  assign run_prbs = running && (active_code == PAT_PRBS7);
  assign run_cust = running && (active_code == PAT_CUST80);
  assign run_scr  = running && (active_code == PAT_SEM || active_code == PAT_EYE);

  pg_prbs7 u_prbs (
    .clk(clk), .rst(rst), .clear(seq_rst), .adv(run_prbs), .sym(prbs_s)
  );

  pg_cust80 u_cust (
    .clk(clk), .rst(rst), .clear(seq_rst), .adv(run_cust), .sym(cust_s)
  );

  pg_scr #(.PERIOD(SCR_PERIOD)) u_scr (
    .clk(clk), .rst(rst), .clear(seq_rst), .adv(run_scr),
    .eye(active_code == PAT_EYE), .dout(scr_d), .ctrl(scr_k)
  );

  always_comb begin
    sym      = '0;
    sym_raw  = 1'b0;
    if (run_d102) begin
      sym = D102_SYM; sym_raw = 1'b1;
    end else if (run_prbs) begin
      sym = prbs_s;   sym_raw = 1'b1;
    end else if (run_cust) begin
      sym = cust_s;   sym_raw = 1'b1;
    end
  end

  assign scr_valid = run_scr;
  assign scr_byte  = run_scr ? scr_d : '0;
  assign scr_ctrl  = run_scr && scr_k;
  assign link_on   = running;
endmodule

// File: rtl/pg_checker.sv
module pg_checker (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [7:0] sel_raw,
  input logic       rev12,
  input logic [9:0] sym,
  input logic       sym_raw,
  input logic [7:0] scr_byte,
  input logic       scr_ctrl,
  input logic       scr_valid,
  input logic       link_on,
  input logic       sel_err,
  input logic       seq_dis,
  input logic       seq_rst,
  input logic       seq_clr,
  input logic       running,
  input logic [2:0] active_code
);
  a_r2_reject: assert property (@(posedge clk) disable iff (rst)
    (start && rev12 && sel_raw[2:0] > 3'd5) |=> (sel_err && !link_on));

  a_r3_dis_then_rst: assert property (@(posedge clk) disable iff (rst)
    (seq_dis && !start) |=> seq_rst);

  a_r3_rst_then_clr: assert property (@(posedge clk) disable iff (rst)
    (seq_rst && !start) |=> seq_clr);

  a_r3_clr_then_run: assert property (@(posedge clk) disable iff (rst)
    (seq_clr && !start) |=> (running && link_on));

  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !link_on |-> (sym == 10'd0 && !sym_raw && !scr_valid && scr_byte == 8'd0 && !scr_ctrl));

  a_r4_code_held: assert property (@(posedge clk) disable iff (rst)
    (running && !start) |=> $stable(active_code));

  a_r8_ctrl_in_scr: assert property (@(posedge clk) disable iff (rst)
    scr_ctrl |-> (scr_valid && !sym_raw && sym == 10'd0));

  a_r8_paths_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(scr_valid && sym_raw));
endmodule

bind phy_pattern_gen pg_checker u_chk (
  .clk(clk), .rst(rst), .start(start), .sel_raw(sel_raw), .rev12(rev12),
  .sym(sym), .sym_raw(sym_raw), .scr_byte(scr_byte), .scr_ctrl(scr_ctrl),
  .scr_valid(scr_valid), .link_on(link_on), .sel_err(sel_err),
  .seq_dis(seq_dis), .seq_rst(seq_rst), .seq_clr(seq_clr),
  .running(running), .active_code(active_code)
);

// File: tb/phy_pattern_gen_test.sv
module phy_pattern_gen_test;
  localparam int P = 12;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] sel_raw = '0;
  logic rev12 = 1'b0;
  logic start = 1'b0;
  logic [9:0] sym;
  logic sym_raw, scr_ctrl, scr_valid, link_on, sel_err;
  logic [7:0] scr_byte;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  phy_pattern_gen #(.SCR_PERIOD(P)) uut (
    .clk(clk), .rst(rst), .sel_raw(sel_raw), .rev12(rev12), .start(start),
    .sym(sym), .sym_raw(sym_raw), .scr_byte(scr_byte), .scr_ctrl(scr_ctrl),
    .scr_valid(scr_valid), .link_on(link_on), .sel_err(sel_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_quiet(input string req);
    check(req, {20'd0, sym_raw, scr_valid, scr_ctrl, sym, scr_byte}, 32'd0);
  endtask

  // strobe start; returns at the cycle the first pattern symbol shows
  task automatic kick(input logic [7:0] raw, input logic r12, input bit valid);
    sel_raw = raw; rev12 = r12; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R3 disable cycle quiet", {31'd0, link_on}, 32'd0);
    if (valid) begin
      @(negedge clk);
      check("R3 reset cycle off", {31'd0, link_on}, 32'd0);
      @(negedge clk);
      check_quiet("R3 clear cycle quiet");
      check("R3 clear cycle off", {31'd0, link_on}, 32'd0);
      @(negedge clk);
      check("R3 link on after three cycles", {31'd0, link_on}, 32'd1);
    end
  endtask

  // bench model of the PRBS7 bit stream
  logic [6:0] pm;
  function automatic logic [9:0] prbs_next();
    logic [9:0] y;
    logic b;
    for (int i = 0; i < 10; i++) begin
      b = pm[6] ^ pm[5];
      y[i] = b;
      pm = {pm[5:0], b};
    end
    return y;
  endfunction

  logic [15:0] sm;
  function automatic logic [7:0] scr_next();
    logic [7:0] y;
    logic t;
    for (int i = 0; i < 8; i++) begin
      t = sm[15];
      y[i] = t;
      sm = {sm[14:0], 1'b0};
      if (t) begin
        sm[0] = ~sm[0]; sm[3] = ~sm[3]; sm[4] = ~sm[4]; sm[5] = ~sm[5];
      end
    end
    return y;
  endfunction

  task automatic run_scr(input logic [7:0] kch, input string req);
    for (int n = 0; n < 3 * P; n++) begin
      if (n % P == 0) begin
        check({req, " R8 control char"}, {23'd0, scr_valid, scr_ctrl, scr_byte}, {23'd0, 1'b1, 1'b1, kch});
        sm = 16'hFFFF;
      end else begin
        check({req, " R9 scrambled data"}, {23'd0, scr_valid, scr_ctrl, scr_byte}, {23'd0, 1'b1, 1'b0, scr_next()});
      end
      check({req, " R8 line path idle"}, {21'd0, sym_raw, sym}, 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    logic [79:0] cw;
    logic [2:0] m;
    cw = 80'hF83E_0F83E0F8_3E0F83E0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11 reset link_on", {31'd0, link_on}, 32'd0);
    check("R11 reset sel_err", {31'd0, sel_err}, 32'd0);
    check_quiet("R11 reset outputs");

    // R1 / R2 exhaustive sweep of the raw byte under both revisions
    for (int r = 0; r < 2; r++) begin
      for (int v = 0; v < 256; v++) begin
        m = (r == 1) ? 3'(v % 8) : 3'(v % 4);
        kick(8'(v), r[0], m <= 3'd5);
        if (m > 3'd5) begin
          check("R2 reject flag", {31'd0, sel_err}, 32'd1);
          @(negedge clk); @(negedge clk); @(negedge clk);
          check("R2 reject stays idle", {31'd0, link_on}, 32'd0);
          check_quiet("R2 reject outputs zero");
        end else begin
          check("R1 accepted code no error", {31'd0, sel_err}, 32'd0);
          if (m == 3'd0) check_quiet("R10 code none outputs zero");
          if (m == 3'd1) check("R1 R5 D10.2 symbol", {21'd0, sym_raw, sym}, {21'd0, 1'b1, 10'b0101010101});
          if (m == 3'd3) check("R1 PRBS7 line path", {31'd0, sym_raw}, 32'd1);
          if (m == 3'd4) check("R1 custom first chunk", {22'd0, sym}, {22'd0, cw[9:0]});
          if (m == 3'd2 || m == 3'd5)
            check("R1 scrambled path", {24'd0, scr_byte}, {24'd0, (m == 3'd5) ? 8'hBC : 8'h1C});
        end
      end
    end

    // R5 D10.2 steady
    kick(8'h01, 1'b0, 1'b1);
    for (int n = 0; n < 10; n++) begin
      check("R5 D10.2 steady", {21'd0, sym_raw, sym}, {21'd0, 1'b1, 10'b0101010101});
      @(negedge clk);
    end

    // R6 PRBS7 beyond a full cycle; R4 selection change mid-run ignored
    kick(8'hF3, 1'b0, 1'b1);
    pm = 7'h7F;
    for (int n = 0; n < 30; n++) begin
      if (n == 10) begin sel_raw = 8'h01; rev12 = 1'b1; end
      check(n >= 10 ? "R4 R6 PRBS7 after select change" : "R6 PRBS7 symbol",
            {21'd0, sym_raw, sym}, {21'd0, 1'b1, prbs_next()});
      @(negedge clk);
    end
    // R4 restart reseeds
    kick(8'h03, 1'b1, 1'b1);
    pm = 7'h7F;
    for (int n = 0; n < 5; n++) begin
      check("R4 restart reseeds PRBS7", {22'd0, sym}, {22'd0, prbs_next()});
      @(negedge clk);
    end

    // R7 custom word wraps
    kick(8'hFC, 1'b1, 1'b1);
    for (int n = 0; n < 24; n++) begin
      check("R7 custom chunk", {21'd0, sym_raw, sym}, {21'd0, 1'b1, cw[(n % 8) * 10 +: 10]});
      @(negedge clk);
    end

    // R8 / R9 scrambled modes; symbol-error code via 2-bit mask of 8'h06
    kick(8'h06, 1'b0, 1'b1);
    run_scr(8'h1C, "SEM");
    kick(8'h05, 1'b1, 1'b1);
    run_scr(8'hBC, "EYE");

    // R2 error cleared by a later valid start
    kick(8'h07, 1'b1, 1'b0);
    check("R2 error raised", {31'd0, sel_err}, 32'd1);
    kick(8'h01, 1'b1, 1'b1);
    check("R2 error cleared", {31'd0, sel_err}, 32'd0);

    // R11 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11 mid-run reset link off", {31'd0, link_on}, 32'd0);
    check_quiet("R11 mid-run reset outputs");
    @(negedge clk);
    check("R11 stays idle", {31'd0, link_on}, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule